// File: doc/BRIEF.md
# Memory Bus Cycle Controller

This block is the processor-side master for single transfers to a slow memory that sits on separate address, data and control lines. A requester presents an address, a read/write command and, for writes, the data to store. The controller then runs the bus cycle in a fixed order. It puts the address out first, then drops the active-low read or write strobe. For a write it drives the data bus only once the strobe is already low. It holds the strobe low through wait states until memory reports it is ready, and it releases the strobe to end the cycle.

Read data is taken from the memory's data lines while the read strobe is still low. It is returned to the requester together with a one-cycle completion pulse. Only one transfer is in flight at a time. The data bus is modelled as a separate output value, input value and output enable, so a pad ring or a bench can resolve it. The parameter `MIN_WAIT` sets a floor on the number of wait cycles, whatever the memory reports.

Top module: `memcyc_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both strobes are high, `mem_dout_en` and `done` are low and `req_ready` is high; reset taken during a transfer returns the bus to that state.
- R2: `mem_addr` carries the accepted address for one full cycle with both strobes high before a strobe falls, and it does not change while a strobe is low.
- R3: A read (`req_write`=0) drives only `mem_rd_n` low; `mem_wr_n` stays high and `mem_dout_en` stays low for the whole read.
- R4: A write (`req_write`=1) drives only `mem_wr_n` low. `mem_dout_en` rises exactly one cycle after `mem_wr_n` falls, is high only while `mem_wr_n` is low, and `mem_dout` equals the accepted write data while it is high.
- R5: The wait phase lasts W cycles, where W is the first count of at least `MIN_WAIT` at which `mem_ready` is sampled high. The strobe is therefore low for exactly 1+W cycles.
- R6: For a read, `done_rdata` during the `done` cycle equals the `mem_din` value sampled at the last wait cycle, before the read strobe rises.
- R7: `done` is high for exactly one cycle. It comes in the cycle right after the strobe returns high, which is 2+W clock edges after the accepting edge.
- R8: A request is accepted only on an edge where `req_ready` is high. `req_ready` is low from the accepting edge until the cycle after `done`, and a request raised while busy and withdrawn before then starts no transfer.
- R9: `mem_rd_n` and `mem_wr_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DATA_W | Read data, valid with `done` |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_dout | output | DATA_W | Data driven toward memory |
| mem_dout_en | output | 1 | Enable for `mem_dout` |
| mem_din | input | DATA_W | Data returned by memory |
| mem_ready | input | 1 | Memory ready, sampled each wait cycle |

## Verification
The cases that are hard to reach from the ports are at the edges of the wait phase. One is memory reporting ready before the `MIN_WAIT` floor has passed, where the floor must win. The other is memory holding ready low well past the floor. The bench's memory model raises `mem_ready` after a programmed number of strobe-low cycles, chosen per transfer as zero, exactly the floor, or far beyond it. When `rd_n` is high or ready is low, the model returns a poison value on `mem_din`, so a capture in the wrong cycle shows up. A second request is injected and withdrawn in the middle of a transfer to show it is ignored.

// File: rtl/memcyc_pkg.sv
package memcyc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_STRB = 3'd2,
        PH_WAIT = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   wr;
        logic   rd_n;
        logic   wr_n;
        logic   oe;
        logic   done;
    } seq_t;

endpackage

// File: rtl/memcyc_wait_timer.sv
module memcyc_wait_timer #(
    parameter int MIN_WAIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic min_met
);
    localparam int CW = (MIN_WAIT < 1) ? 1 : $clog2(MIN_WAIT + 1);
    localparam int FLOOR = (MIN_WAIT < 1) ? 1 : MIN_WAIT;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != CW'(FLOOR)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // counts completed wait cycles; the floor is reached in the cycle
    // that makes the count equal to FLOOR
    assign min_met = run && (cnt_q >= CW'(FLOOR - 1));

endmodule

// File: rtl/memcyc_seq.sv
module memcyc_seq
    import memcyc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic min_met,
    input  logic mem_ready,
    output logic req_ready,
    output logic accept,
    output logic in_wait,
    output logic capture,
    output logic rd_n,
    output logic wr_n,
    output logic oe,
    output logic done
);
    seq_t s_d, s_q;
    logic finish;

    assign finish = (s_q.ph == PH_WAIT) && min_met && mem_ready;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.ph = PH_ADDR;
                    s_d.wr = req_write;
                end
            end
            PH_ADDR: begin
                s_d.ph = PH_STRB;
                if (s_q.wr) begin
                    s_d.wr_n = 1'b0;
                end else begin
                    s_d.rd_n = 1'b0;
                end
            end
            PH_STRB: begin
                s_d.ph = PH_WAIT;
                s_d.oe = s_q.wr;
            end
            PH_WAIT: begin
                if (finish) begin
                    s_d.ph   = PH_DONE;
                    s_d.rd_n = 1'b1;
                    s_d.wr_n = 1'b1;
                    s_d.oe   = 1'b0;
                    s_d.done = 1'b1;
                end
            end
            PH_DONE: begin
                s_d.ph = PH_IDLE;
            end
            default: begin
                s_d.ph   = PH_IDLE;
                s_d.rd_n = 1'b1;
                s_d.wr_n = 1'b1;
                s_d.oe   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, wr: 1'b0, rd_n: 1'b1, wr_n: 1'b1,
                     oe: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.ph == PH_IDLE);
    assign accept    = req_ready && req_valid;
    assign in_wait   = (s_q.ph == PH_WAIT);
    assign capture   = finish && !s_q.wr;
    assign rd_n      = s_q.rd_n;
    assign wr_n      = s_q.wr_n;
    assign oe        = s_q.oe;
    assign done      = s_q.done;

endmodule

// File: rtl/memcyc_datapath.sv
module memcyc_datapath #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_din,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } dp_t;

    dp_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (load) begin
            d_d.addr  = req_addr;
            d_d.wdata = req_wdata;
        end
        if (capture) begin
            d_d.rdata = mem_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign addr  = d_q.addr;
    assign wdata = d_q.wdata;
    assign rdata = d_q.rdata;

endmodule

// File: rtl/memcyc_ctrl.sv
module memcyc_ctrl #(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int MIN_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din,
    input  logic              mem_ready
);
    logic accept;
    logic in_wait;
    logic capture;
    logic min_met;

    memcyc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .min_met   (min_met),
        .mem_ready (mem_ready),
        .req_ready (req_ready),
        .accept    (accept),
        .in_wait   (in_wait),
        .capture   (capture),
        .rd_n      (mem_rd_n),
        .wr_n      (mem_wr_n),
        .oe        (mem_dout_en),
        .done      (done)
    );

    memcyc_wait_timer #(
        .MIN_WAIT (MIN_WAIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_wait),
        .min_met (min_met)
    );

    memcyc_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_din   (mem_din),
        .addr      (mem_addr),
        .wdata     (mem_dout),
        .rdata     (done_rdata)
    );

endmodule

// File: rtl/memcyc_ctrl_chk.sv
module memcyc_ctrl_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en
);
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    // R4
    drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> !mem_wr_n);

    // R4
    drive_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dout_en) |-> $past(!mem_wr_n));

    // R4
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dout_en && $past(mem_dout_en)) |-> $stable(mem_dout));

    // R2
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_rd_n) || $fell(mem_wr_n)) |-> $stable(mem_addr));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!mem_rd_n && $past(!mem_rd_n)) || (!mem_wr_n && $past(!mem_wr_n)))
        |-> $stable(mem_addr));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (mem_rd_n && mem_wr_n && $past(!mem_rd_n || !mem_wr_n)));

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind memcyc_ctrl memcyc_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .done        (done),
    .mem_addr    (mem_addr),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en)
);

// File: tb/memcyc_ctrl_tb.sv
module memcyc_ctrl_tb;
    localparam int AW   = 20;
    localparam int DW   = 16;
    localparam int MINW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, done;
    logic [DW-1:0] done_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_n, mem_wr_n, mem_dout_en;
    logic [DW-1:0] mem_dout, mem_din;
    logic          mem_ready;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    memcyc_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MIN_WAIT(MINW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .done_rdata(done_rdata), .mem_addr(mem_addr),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_ready(mem_ready)
    );

    // ---------------- memory model ----------------
    logic [DW-1:0] bus_mem [16];
    logic [DW-1:0] exp_mem [16];
    int            lowcnt = 0;
    int            dly = 0;

    function automatic logic [DW-1:0] seed_val(int i);
        return DW'(16'hA000 ^ (i * 16'h0137));
    endfunction

    function automatic logic [DW-1:0] poison(logic [AW-1:0] a);
        return ~bus_mem[a[3:0]] ^ 16'h5A5A;
    endfunction

    function automatic int wait_len(int d);
        return (d > MINW) ? d : MINW;
    endfunction

    always @(posedge clk) begin
        if (!mem_rd_n || !mem_wr_n) lowcnt <= lowcnt + 1;
        else                        lowcnt <= 0;
        if (!mem_wr_n && mem_dout_en) bus_mem[mem_addr[3:0]] <= mem_dout;
    end

    assign mem_ready = (!mem_rd_n || !mem_wr_n) && (lowcnt >= dly);
    assign mem_din   = (!mem_rd_n && mem_ready) ? bus_mem[mem_addr[3:0]]
                                                : poison(mem_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- one transfer ----------------
    task automatic xfer(input bit wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input int d, input bit intrude);
        int  w = wait_len(d);
        int  n;
        int  low = 0, oe_cnt = 0, done_at = -1;
        bit  addr_ok = 1, strobe_ok = 1, oe_ok = 1, dat_ok = 1, busy_ok = 1;
        bit  setup_ok;
        logic [DW-1:0] rd_seen = '0;
        @(negedge clk);
        dly = d;
        chk(req_ready === 1'b1, "R8", "ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~wd;
        setup_ok = (mem_addr === a) && mem_rd_n && mem_wr_n;
        chk(setup_ok, "R2", "address before strobe", 32'(mem_addr), 32'(a));
        n = 0;
        while (done_at < 0 && n < 60) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (intrude && n == 1) begin
                req_valid = 1'b1; req_write = ~wr; req_addr = a ^ 20'h00005;
            end
            if (intrude && n == 3) req_valid = 1'b0;
            if (!mem_rd_n || !mem_wr_n) begin
                low++;
                if (mem_addr !== a) addr_ok = 0;
            end
            if (wr ? !mem_rd_n : !mem_wr_n) strobe_ok = 0;
            if (mem_dout_en) begin
                oe_cnt++;
                if (!wr || n < 2 || mem_wr_n) oe_ok = 0;
                if (mem_dout !== wd) dat_ok = 0;
            end
            if (done) done_at = n;
            else if (req_ready) busy_ok = 0;
        end
        if (done_at >= 0) rd_seen = done_rdata;
        chk(addr_ok, "R2", "address held while strobe low", 32'(low), 32'(w + 1));
        chk(strobe_ok, wr ? "R4" : "R3", "only own strobe used", 0, 0);
        chk(low == w + 1, "R5", "strobe low cycles", 32'(low), 32'(w + 1));
        chk(done_at == w + 2, "R7", "done latency", 32'(done_at), 32'(w + 2));
        chk(busy_ok, "R8", "ready low while busy", 0, 0);
        if (wr) begin
            chk(oe_ok && oe_cnt == w, "R4", "drive window", 32'(oe_cnt), 32'(w));
            chk(dat_ok, "R4", "driven data", 32'(mem_dout), 32'(wd));
            exp_mem[a[3:0]] = wd;
        end else begin
            chk(oe_cnt == 0, "R3", "no drive on read", 32'(oe_cnt), 0);
            chk(rd_seen === exp_mem[a[3:0]], "R6", "read data",
                32'(rd_seen), 32'(exp_mem[a[3:0]]));
        end
        @(negedge clk);
        chk(!done && req_ready, "R7", "done one cycle, ready back",
            32'({done, req_ready}), 32'b01);
        if (intrude) begin
            bit quiet = 1;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (!mem_rd_n || !mem_wr_n || !req_ready) quiet = 0;
            end
            chk(quiet, "R8", "busy-time request ignored", 0, 0);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 16; i++) begin
            bus_mem[i] = seed_val(i);
            exp_mem[i] = seed_val(i);
        end
        repeat (3) @(negedge clk);
        chk(mem_rd_n && mem_wr_n && !mem_dout_en && !done && req_ready, "R1",
            "state during reset",
            32'({mem_rd_n, mem_wr_n, mem_dout_en, done, req_ready}), 32'b11001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_rd_n && mem_wr_n && !mem_dout_en && !done && req_ready, "R1",
            "state after reset",
            32'({mem_rd_n, mem_wr_n, mem_dout_en, done, req_ready}), 32'b11001);

        // directed corners: ready early, at floor, late
        xfer(1'b0, 20'h12343, '0, 0, 1'b0);
        xfer(1'b1, 20'hABCD3, 16'hBEEF, 0, 1'b0);
        xfer(1'b0, 20'h00003, '0, MINW, 1'b0);
        xfer(1'b1, 20'hFFFF7, 16'h1234, 9, 1'b0);
        xfer(1'b0, 20'h55557, '0, 9, 1'b0);
        xfer(1'b0, 20'h2000A, '0, 4, 1'b1);
        xfer(1'b1, 20'h3000B, 16'hC0DE, 3, 1'b1);

        for (int t = 0; t < 40; t++) begin
            bit            w  = 1'($urandom);
            logic [AW-1:0] a  = AW'($urandom);
            logic [DW-1:0] wd = DW'($urandom);
            int            d  = int'($urandom % 7);
            xfer(w, a, wd, d, 1'b0);
        end

        // reset in the middle of a write
        @(negedge clk);
        dly = 20;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h0000C; req_wdata = 16'h7777;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(mem_rd_n && mem_wr_n && !mem_dout_en && !done && req_ready, "R1",
            "reset during transfer",
            32'({mem_rd_n, mem_wr_n, mem_dout_en, done, req_ready}), 32'b11001);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_rd_n && mem_wr_n && !mem_dout_en && req_ready, "R1",
            "idle after mid reset",
            32'({mem_rd_n, mem_wr_n, mem_dout_en, req_ready}), 32'b1101);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule